// File: doc/BRIEF.md
# Dual-Lane Science Link Serializer

This block turns parallel pixel samples into bit streams on two serial science links. Lane 0 carries the left readout ports and lane 1 the right readout ports. Each lane shares its link between sensor A and sensor B. Every lane drives three lines: a data line, a bit clock and an enable. The receiver is told nothing explicit about framing. A row is one unbroken burst with the enable high. The end of a frame is a long quiet period that the receiver detects by timing out. When the test mode is on, a synthetic ramp image takes the lane in place of camera data.

Samples come in on four valid/ready source ports. Source index `2*lane + sensor` uses sensor 0 for A and sensor 1 for B. Each sample carries two flags, "last in row" and "last in frame". A lane raises `ready` for exactly one source, only at a bit boundary where it can start a new word, and whether or not `valid` is high. A word is taken in the clock cycle where `valid` and `ready` are both high. The lane holds no buffer beyond the shift register, so a source must offer its sample at that boundary. If it does not, the lane drops the enable until a later boundary (an underrun).

The sensor selection and the test mode are sampled at the first word of each frame and held until that frame ends.

Top module: `sci_link_serializer`

## Requirements
- R1: While reset is held, every `lnk_en`, every `lnk_dat` and every `src_ready` is 0.
- R2: Each bit lasts BIT_CYC clock cycles. The bit clock is low for the first half of the bit and high for the second half. Data and enable change only at the start of a bit. Each word is sent MSB first as PIX_W bits.
- R3: With `cam_act` = 2'b11 (bit 0 = sensor A, bit 1 = sensor B), a lane alternates samples A, B, A, B, starting with A. Only sensor B's row and frame flags end a row or a frame, so a row holds two words per column.
- R4: With only one sensor active, the lane sends only that sensor's samples, and it never raises `ready` toward the inactive sensor.
- R5: A row is one contiguous enable-high burst, and its length is a whole number of words. Words follow each other with no idle bit while the source keeps `valid` high.
- R6: After a row that does not end the frame, the enable stays low for exactly ROW_GAP bit periods, provided the next sample is valid.
- R7: After the word that ends a frame, the enable stays low for exactly max(FRAME_GAP, 4*ROW_GAP) bit periods, provided the next sample is valid.
- R8: With `tp_mode` set, the lane sends a ramp in which each pixel equals (row + column) truncated to PIX_W bits. A row has TP_COLS pixels and a frame has TP_ROWS rows. No camera `ready` is raised.
- R9: A change of `cam_act` or `tp_mode` in the middle of a frame takes effect only at the first word of the next frame.
- R10: The two lanes run independently of each other. Lane 0 serves sources 0 and 1, and lane 1 serves sources 2 and 3.
- R11: With `cam_act` = 2'b00 and `tp_mode` clear, the enable stays low and no `ready` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cam_act | input | 2 | Active sensors: bit 0 = A, bit 1 = B |
| tp_mode | input | 1 | Replace camera data with the ramp |
| src_valid | input | 4 | Sample valid, index 2*lane+sensor |
| src_ready | output | 4 | Sample accepted when valid and ready are both high |
| src_data | input | 4*PIX_W | Samples; source i occupies bits i*PIX_W upward |
| src_row_last | input | 4 | Sample is the last of its row |
| src_frame_last | input | 4 | Sample is the last of its frame |
| lnk_clk | output | 2 | Bit clock per lane |
| lnk_dat | output | 2 | Serial data per lane |
| lnk_en | output | 2 | Row enable per lane |

## Verification
Two events land on the same bit boundary. One is the shifting of the last bit of a word. The other is the handshake and loading of the next word. At a row's end the same boundary also decides which gap length follows.

The bench provokes this with sources whose `valid` never drops. It then judges the result through the word count of each burst, checks that no partial word appears, and measures the exact low run between bursts.

A second coincidence is a change of mode requested mid-frame against the frame boundary where the mode is re-sampled. The bench switches `cam_act` during the second row and expects the interleaved pattern to hold to the end of that frame and the single-sensor pattern to begin with the next.

// File: rtl/sds_pkg.sv
package sds_pkg;
  typedef enum logic [1:0] {LN_IDLE, LN_SHIFT, LN_GAP} lane_st_e;

  function automatic int gap_floor(input int row_gap, input int frame_gap);
    return (frame_gap > 4 * row_gap) ? frame_gap : 4 * row_gap;
  endfunction
endpackage

// File: rtl/sds_bitclk.sv
module sds_bitclk #(
  parameter int BIT_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick,
  output logic bclk
);
  localparam int PH_W = (BIT_CYC > 2) ? $clog2(BIT_CYC) : 1;
  localparam int HALF = BIT_CYC / 2;

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= '0;
    else if (tick) phase <= '0;
    else phase <= phase + PH_W'(1);
  end

  assign tick = (phase == PH_W'(BIT_CYC - 1));
  assign bclk = (phase >= PH_W'(HALF));
endmodule

// File: rtl/sds_ramp.sv
module sds_ramp #(
  parameter int PIX_W   = 14,
  parameter int TP_COLS = 8,
  parameter int TP_ROWS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [PIX_W-1:0] pix,
  output logic             row_last,
  output logic             frame_last
);
  localparam int CW = (TP_COLS > 1) ? $clog2(TP_COLS) : 1;
  localparam int RW = (TP_ROWS > 1) ? $clog2(TP_ROWS) : 1;

  logic [CW-1:0] col;
  logic [RW-1:0] row;

  assign row_last   = (col == CW'(TP_COLS - 1));
  assign frame_last = row_last && (row == RW'(TP_ROWS - 1));
  assign pix        = PIX_W'(row) + PIX_W'(col);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
    end else if (adv) begin
      if (row_last) begin
        col <= '0;
        row <= frame_last ? '0 : row + RW'(1);
      end else begin
        col <= col + CW'(1);
      end
    end
  end
endmodule

// File: rtl/sds_piso.sv
module sds_piso #(
  parameter int PIX_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PIX_W-1:0] word,
  input  logic             adv,
  output logic             msb,
  output logic             last
);
  localparam int IW = $clog2(PIX_W);

  logic [PIX_W-1:0] sreg;
  logic [IW-1:0]    idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg <= '0;
      idx  <= '0;
    end else if (load) begin
      sreg <= word;
      idx  <= '0;
    end else if (adv) begin
      sreg <= {sreg[PIX_W-2:0], 1'b0};
      idx  <= idx + IW'(1);
    end
  end

  assign msb  = sreg[PIX_W-1];
  assign last = (idx == IW'(PIX_W - 1));

  // R2
  no_shift_past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> !last);
endmodule

// File: rtl/sds_lane.sv
module sds_lane
  import sds_pkg::*;
#(
  parameter int PIX_W     = 14,
  parameter int ROW_GAP   = 4,
  parameter int FRAME_GAP = 16,
  parameter int TP_COLS   = 8,
  parameter int TP_ROWS   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [1:0]         act,
  input  logic               tp,
  input  logic [1:0]         cv,
  input  logic [2*PIX_W-1:0] cd,
  input  logic [1:0]         crl,
  input  logic [1:0]         cfl,
  output logic [1:0]         crdy,
  output logic               sd,
  output logic               en
);
  localparam int GW = $clog2(FRAME_GAP + 1);
  localparam int IW = $clog2(PIX_W);
  localparam int LW = $clog2(ROW_GAP + 1);

  lane_st_e         st;
  logic [GW-1:0]    gap_cnt;
  logic             turn, in_frame, m_tp;
  logic [1:0]       m_act;
  logic             cur_row_end, cur_frame_end;

  logic             eff_tp, both, sel, slot, cam_on, has, take, term;
  logic [1:0]       eff_act;
  logic [PIX_W-1:0] word, tp_pix;
  logic             w_re, w_fe, tp_rl, tp_fl, last_bit, msb, adv;

  always_comb begin
    eff_tp  = in_frame ? m_tp : tp;
    eff_act = in_frame ? m_act : act;
    both    = (eff_act == 2'b11);
    sel     = both ? turn : eff_act[1];
    term    = !both || sel;
    slot    = tick && ((st == LN_IDLE) ||
                       (st == LN_SHIFT && last_bit && !cur_row_end) ||
                       (st == LN_GAP && gap_cnt == GW'(1)));
    cam_on  = !eff_tp && (eff_act != 2'b00);
    has     = eff_tp || (cam_on && cv[sel]);
    take    = slot && has;
    crdy    = (slot && cam_on) ? (sel ? 2'b10 : 2'b01) : 2'b00;
    word    = eff_tp ? tp_pix : (sel ? cd[2*PIX_W-1:PIX_W] : cd[PIX_W-1:0]);
    w_fe    = eff_tp ? tp_fl : (cfl[sel] && term);
    w_re    = (eff_tp ? tp_rl : (crl[sel] && term)) || w_fe;
    adv     = tick && (st == LN_SHIFT) && !last_bit;
  end

  sds_ramp #(.PIX_W(PIX_W), .TP_COLS(TP_COLS), .TP_ROWS(TP_ROWS)) u_ramp (
    .clk(clk), .rst_n(rst_n), .adv(take && eff_tp),
    .pix(tp_pix), .row_last(tp_rl), .frame_last(tp_fl));

  sds_piso #(.PIX_W(PIX_W)) u_piso (
    .clk(clk), .rst_n(rst_n), .load(take), .word(word), .adv(adv),
    .msb(msb), .last(last_bit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= LN_IDLE;
      gap_cnt       <= '0;
      turn          <= 1'b0;
      in_frame      <= 1'b0;
      m_tp          <= 1'b0;
      m_act         <= 2'b00;
      cur_row_end   <= 1'b0;
      cur_frame_end <= 1'b0;
    end else if (tick) begin
      if (take) begin
        st            <= LN_SHIFT;
        cur_row_end   <= w_re;
        cur_frame_end <= w_fe;
        in_frame      <= 1'b1;
        m_tp          <= eff_tp;
        m_act         <= eff_act;
        turn          <= both ? ~sel : 1'b0;
      end else begin
        unique case (st)
          LN_IDLE: st <= LN_IDLE;
          LN_SHIFT: begin
            if (last_bit) begin
              if (cur_row_end) begin
                st      <= LN_GAP;
                gap_cnt <= cur_frame_end ? GW'(FRAME_GAP) : GW'(ROW_GAP);
                if (cur_frame_end) in_frame <= 1'b0;
              end else begin
                st <= LN_IDLE;
              end
            end
          end
          LN_GAP: begin
            if (gap_cnt == GW'(1)) st <= LN_IDLE;
            else gap_cnt <= gap_cnt - GW'(1);
          end
          default: st <= LN_IDLE;
        endcase
      end
    end
  end

  assign en = (st == LN_SHIFT);
  assign sd = en && msb;

  // checker state for burst length and gap length
  logic [IW-1:0] bmod;
  logic [LW-1:0] lowrun;
  logic          en_q, armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bmod   <= '0;
      lowrun <= '0;
      en_q   <= 1'b0;
      armed  <= 1'b0;
    end else begin
      en_q <= en;
      if (!en) bmod <= '0;
      else if (tick) bmod <= (bmod == IW'(PIX_W - 1)) ? '0 : bmod + IW'(1);
      if (en) lowrun <= '0;
      else if (tick && lowrun < LW'(ROW_GAP)) lowrun <= lowrun + LW'(1);
      if (en_q && !en) armed <= cur_row_end;
    end
  end

  // R2
  stable_between_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> ($stable(en) && $stable(sd)));
  // R4
  one_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(crdy));
  // R8
  tp_blocks_cam_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && m_tp) |-> (crdy == 2'b00));
  // R5
  whole_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |-> (bmod == '0));
  // R6
  row_gap_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(en) && armed) |-> (lowrun >= LW'(ROW_GAP)));
endmodule

// File: rtl/sci_link_serializer.sv
module sci_link_serializer #(
  parameter int PIX_W     = 14,
  parameter int BIT_CYC   = 2,
  parameter int ROW_GAP   = 4,
  parameter int FRAME_GAP = 16,
  parameter int TP_COLS   = 8,
  parameter int TP_ROWS   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         cam_act,
  input  logic               tp_mode,
  input  logic [3:0]         src_valid,
  output logic [3:0]         src_ready,
  input  logic [4*PIX_W-1:0] src_data,
  input  logic [3:0]         src_row_last,
  input  logic [3:0]         src_frame_last,
  output logic [1:0]         lnk_clk,
  output logic [1:0]         lnk_dat,
  output logic [1:0]         lnk_en
);
  localparam int LANES  = 2;
  localparam int FG_EFF = sds_pkg::gap_floor(ROW_GAP, FRAME_GAP);

  logic tick, bclk;

  sds_bitclk #(.BIT_CYC(BIT_CYC)) u_bitclk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bclk(bclk));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sds_lane #(
      .PIX_W(PIX_W), .ROW_GAP(ROW_GAP), .FRAME_GAP(FG_EFF),
      .TP_COLS(TP_COLS), .TP_ROWS(TP_ROWS)
    ) u_lane (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .act(cam_act), .tp(tp_mode),
      .cv(src_valid[2*g +: 2]),
      .cd(src_data[2*g*PIX_W +: 2*PIX_W]),
      .crl(src_row_last[2*g +: 2]),
      .cfl(src_frame_last[2*g +: 2]),
      .crdy(src_ready[2*g +: 2]),
      .sd(lnk_dat[g]),
      .en(lnk_en[g]));
    assign lnk_clk[g] = bclk;
  end
endmodule

// File: tb/sci_link_serializer_test.sv
`timescale 1ns/1ps
module sci_link_serializer_test;
  localparam int PW = 14, BC = 2, RG = 4, FG = 16, TC = 8, TR = 4;
  localparam int SR = 3, SC = 4;
  localparam int FGE = (FG > 4 * RG) ? FG : 4 * RG;

  typedef struct packed {
    logic       t;
    logic [1:0] a;
    logic [3:0] rows;
    logic [4:0] wpr;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{1'b0, 2'b11, 4'd3, 5'd8},
    '{1'b0, 2'b01, 4'd3, 5'd4},
    '{1'b0, 2'b10, 4'd3, 5'd4},
    '{1'b1, 2'b00, 4'd4, 5'd8},
    '{1'b1, 2'b11, 4'd4, 5'd8}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]      act = 2'b00;
  logic            tp = 1'b0;
  logic [3:0]      sv, srdy, srl, sfl;
  logic [4*PW-1:0] sdat;
  logic [1:0]      lclk, ldat, len;

  sci_link_serializer #(.PIX_W(PW), .BIT_CYC(BC), .ROW_GAP(RG), .FRAME_GAP(FG),
                        .TP_COLS(TC), .TP_ROWS(TR)) uut (
    .clk(clk), .rst_n(rst_n), .cam_act(act), .tp_mode(tp),
    .src_valid(sv), .src_ready(srdy), .src_data(sdat),
    .src_row_last(srl), .src_frame_last(sfl),
    .lnk_clk(lclk), .lnk_dat(ldat), .lnk_en(len));

  int tests = 0, fails = 0;

  // source model
  int sr [4], sc [4], hs [4];
  always @(posedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (!rst_n) begin
        sr[i] <= 0; sc[i] <= 0; hs[i] <= 0;
      end else if (sv[i] && srdy[i]) begin
        hs[i] <= hs[i] + 1;
        if (sc[i] == SC - 1) begin
          sc[i] <= 0;
          sr[i] <= (sr[i] == SR - 1) ? 0 : sr[i] + 1;
        end else sc[i] <= sc[i] + 1;
      end
    end
  end
  always_comb begin
    for (int i = 0; i < 4; i++) begin
      sv[i] = rst_n;
      sdat[i*PW +: PW] = {1'(i / 2), 1'(i % 2), 4'(sr[i]), 8'(sc[i])};
      srl[i] = (sc[i] == SC - 1);
      sfl[i] = srl[i] && (sr[i] == SR - 1);
    end
  end

  // receiver model
  logic [PW-1:0] rx_w [2][64];
  int rx_len [2][16], rx_gap [2][16];
  int rx_nw [2], rx_rows [2], rx_cur [2], rx_bits [2], rx_low [2], rx_bad [2];
  int cyc [2], started [2];
  logic pclk [2], pen [2], nen [2];
  logic [PW-1:0] acc [2];
  int tim_bad = 0;

  always @(negedge clk) begin
    for (int l = 0; l < 2; l++) begin
      if (!rst_n) begin
        rx_nw[l] = 0; rx_rows[l] = 0; rx_cur[l] = 0; rx_bits[l] = 0;
        rx_low[l] = 0; rx_bad[l] = 0; cyc[l] = 0; started[l] = 0;
        pclk[l] = 1'b0; pen[l] = 1'b0; nen[l] = 1'b0; acc[l] = '0;
        for (int k = 0; k < 64; k++) rx_w[l][k] = '0;
        for (int k = 0; k < 16; k++) begin rx_len[l][k] = 0; rx_gap[l][k] = -1; end
      end else begin
        if (len[l] != nen[l] && lclk[l]) tim_bad++;
        nen[l] = len[l];
        cyc[l]++;
        if (lclk[l] && !pclk[l]) begin
          if (started[l] != 0 && cyc[l] != BC) tim_bad++;
          started[l] = 1;
          cyc[l] = 0;
          if (len[l]) begin
            if (!pen[l]) begin
              if (rx_rows[l] < 16) rx_gap[l][rx_rows[l]] = rx_low[l];
              rx_cur[l] = 0;
            end
            acc[l] = {acc[l][PW-2:0], ldat[l]};
            rx_bits[l]++;
            if (rx_bits[l] == PW) begin
              if (rx_nw[l] < 64) rx_w[l][rx_nw[l]] = acc[l];
              rx_nw[l]++;
              rx_bits[l] = 0;
              rx_cur[l]++;
            end
          end else begin
            if (pen[l]) begin
              if (rx_rows[l] < 16) rx_len[l][rx_rows[l]] = rx_cur[l];
              if (rx_bits[l] != 0) rx_bad[l]++;
              rx_rows[l]++;
              rx_low[l] = 0;
            end
            rx_low[l]++;
          end
          pen[l] = len[l];
        end
        pclk[l] = lclk[l];
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int got, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic logic [PW-1:0] expw(input int l, input logic t,
                                         input logic [1:0] a, input int r, input int k);
    int s, c;
    if (t) return PW'(r + k);
    if (a == 2'b11) begin s = k % 2; c = k / 2; end
    else begin s = (a == 2'b10) ? 1 : 0; c = k; end
    return {1'(l), 1'(s), 4'(r), 8'(c)};
  endfunction

  task automatic do_reset(input logic [1:0] a, input logic t);
    @(negedge clk);
    rst_n = 1'b0; act = a; tp = t;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_rows(input int n);
    int t = 0;
    while ((rx_rows[0] < n || rx_rows[1] < n) && t < 20000) begin
      @(negedge clk); t++;
    end
  endtask

  task automatic check_frame(input int l, input int w0, input int r0, input vec_t v);
    int bad_w = 0, bw_got = 0, bw_exp = 0, bad_len = 0, bl_got = 0;
    int bad_g = 0, bg_got = 0, fg_got;
    string rq;
    rq = v.t ? "R8" : ((v.a == 2'b11) ? "R3" : "R4");
    for (int r = 0; r < int'(v.rows); r++) begin
      if (rx_len[l][r0+r] != int'(v.wpr)) begin bad_len++; bl_got = rx_len[l][r0+r]; end
      for (int k = 0; k < int'(v.wpr); k++) begin
        logic [PW-1:0] e;
        e = expw(l, v.t, v.a, r, k);
        if (rx_w[l][w0 + r*int'(v.wpr) + k] !== e) begin
          if (bad_w == 0) begin bw_got = int'(rx_w[l][w0 + r*int'(v.wpr) + k]); bw_exp = int'(e); end
          bad_w++;
        end
      end
      if (r > 0 && rx_gap[l][r0+r] != RG) begin bad_g++; bg_got = rx_gap[l][r0+r]; end
    end
    fg_got = rx_gap[l][r0 + int'(v.rows)];
    check(bad_w == 0, rq, $sformatf("lane %0d word order/value", l), bw_got, bw_exp);
    check(bad_len == 0 && rx_bad[l] == 0, "R5", $sformatf("lane %0d words per row", l),
          bl_got, int'(v.wpr));
    check(bad_g == 0, "R6", $sformatf("lane %0d row gap", l), bg_got, RG);
    check(fg_got == FGE, "R7", $sformatf("lane %0d frame gap", l), fg_got, FGE);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    rst_n = 1'b0; act = 2'b11; tp = 1'b0;
    repeat (5) @(negedge clk);
    check(len == 2'b00, "R1", "enable in reset", int'(len), 0);
    check(ldat == 2'b00, "R1", "data in reset", int'(ldat), 0);
    check(srdy == 4'b0000, "R1", "ready in reset", int'(srdy), 0);

    // vector table walk
    for (int vi = 0; vi < 5; vi++) begin
      do_reset(VEC[vi].a, VEC[vi].t);
      wait_rows(int'(VEC[vi].rows) + 1);
      for (int l = 0; l < 2; l++) begin
        check_frame(l, 0, 0, VEC[vi]);
        if (!VEC[vi].t)
          check(int'(rx_w[l][0][PW-1]) == l, "R10", "lane bit of first word",
                int'(rx_w[l][0][PW-1]), l);
      end
      if (VEC[vi].t)
        check(hs[0] + hs[1] + hs[2] + hs[3] == 0, "R8", "camera handshakes in test mode",
              hs[0] + hs[1] + hs[2] + hs[3], 0);
      else if (VEC[vi].a == 2'b01)
        check(hs[1] + hs[3] == 0, "R4", "sensor B handshakes when idle", hs[1] + hs[3], 0);
      else if (VEC[vi].a == 2'b10)
        check(hs[0] + hs[2] == 0, "R4", "sensor A handshakes when idle", hs[0] + hs[2], 0);
    end

    // R11: nothing active
    do_reset(2'b00, 1'b0);
    repeat (600) @(negedge clk);
    check(rx_nw[0] + rx_nw[1] == 0, "R11", "words with no source", rx_nw[0] + rx_nw[1], 0);
    check(hs[0] + hs[1] + hs[2] + hs[3] == 0, "R11", "handshakes with no source",
          hs[0] + hs[1] + hs[2] + hs[3], 0);

    // R9: mode change mid-frame
    do_reset(2'b11, 1'b0);
    wait_rows(1);
    @(negedge clk);
    act = 2'b01;
    wait_rows(2 * SR + 1);
    for (int l = 0; l < 2; l++) begin
      check_frame(l, 0, 0, VEC[0]);
      check(rx_len[l][SR-1] == 2 * SC, "R9", "last row of frame keeps old mode",
            rx_len[l][SR-1], 2 * SC);
      check_frame(l, SR * 2 * SC, SR, VEC[1]);
    end

    // R2: bit timing over the whole run
    check(tim_bad == 0, "R2", "bit timing violations", tim_bad, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule